// File: doc/BRIEF.md
# External Bus Turnaround Sequencer

This block runs single accesses on a shared external bus. Each request names one of several address areas and says whether it is a read or a write. The block turns each request into a fixed three-state cycle, A1, A2 and A3. It drives a one-hot chip select for the area, an address latch pulse in A1, and a read or write strobe in A2 and A3. Write data is driven from A1 to A3. Read data is captured at the end of A3.

When a new request is taken in the same state as A3 of the previous access, the two cycles are back to back. Some pairs of back-to-back cycles are hazards because the earlier device may still be driving the data bus:

- a read followed by a read to a different area;
- a read followed by a write;
- a write followed by a read.

For a hazard pair, the block puts one or two turnaround states in front of A1 of the later access. A small configuration register picks the gap length and enables each hazard kind separately. A build parameter can remove the read-after-write case completely.

Top module: `ext_bus_turnaround`

## Requirements
- R1: An accepted access runs exactly three states. In A1 the chip select of its area is high and `busAle` is high. In A2 and A3 the chip select stays high and `busAle` is low. `done` is high for one cycle right after A3. The chip select is one-hot over the areas and zero outside an access.
- R2: In a write access, `busWr` is high in A2 and A3, and `busDoutEn` is high from A1 to A3 with `busDout` equal to the request's write data. In a read access, `busRd` is high in A2 and A3, and `rdData` holds the value of `busDin` sampled at the end of A3, visible in the same cycle as `done`.
- R3: A back-to-back read followed by a read to a different area is preceded by turnaround states when `cfgData` bit 1 is set.
- R4: A back-to-back read followed by a read to the same area never gets turnaround states.
- R5: A back-to-back write after a read is preceded by turnaround states when bit 2 is set.
- R6: A back-to-back read after a write is preceded by turnaround states when bit 3 is set and `RAW_GAP_EN` is 1. With `RAW_GAP_EN` = 0 it never gets turnaround states.
- R7: Bit 0 clear gives a one-state gap. Bit 0 set gives a two-state gap.
- R8: During turnaround states, all chip selects, `busRd`, `busWr` and `busDoutEn` are low, and `busAddr` keeps its previous value. `busAddr` changes only in a cycle where `busAle` is high.
- R9: A write followed by a write never gets turnaround states. An access that starts after at least one free bus state gets no turnaround states.
- R10: After reset, the configuration is bit 0 = 0 and bits 1, 2 and 3 = 1. A pulse on `cfgWrite` loads `cfgData`.
- R11: `reqReady` is high only while the bus is free or in A3. After reset it is high. A request is taken on a clock edge where both `reqValid` and `reqReady` are high.
- R12: Clearing a hazard's enable bit removes the gap for that hazard only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bus state per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrite | input | 1 | Loads `cfgData` into the configuration register |
| cfgData | input | 4 | Bit 0 two-state gap, bit 1 read/read area change, bit 2 write after read, bit 3 read after write |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request can be taken this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqArea | input | $clog2(NUM_AREAS) | Target area |
| reqAddr | input | ADDR_W | Access address |
| reqWdata | input | DATA_W | Write data |
| busCs | output | NUM_AREAS | Active-high chip select per area |
| busAle | output | 1 | Address latch pulse in A1 |
| busRd | output | 1 | Read strobe |
| busWr | output | 1 | Write strobe |
| busAddr | output | ADDR_W | External address |
| busDout | output | DATA_W | Write data to the bus |
| busDoutEn | output | 1 | Write data drive enable |
| busDin | input | DATA_W | Read data from the bus |
| rdData | output | DATA_W | Captured read data |
| done | output | 1 | One-cycle pulse after A3 |

## Verification
The bench builds the main instance with its defaults: eight areas and the read-after-write gap present. It writes several configuration values to reach one-state gaps, two-state gaps, all hazards disabled, and only the area-change case disabled. A second instance is built with `RAW_GAP_EN` = 0 and runs a back-to-back write then read to the same area. That variant must show no gap where the default build inserts one. A request held off for exactly one state shows that the free state replaces the turnaround instead of adding to it.

// File: rtl/ebt_pkg.sv
package ebt_pkg;
  localparam int CFG_W = 4;
  localparam int CFG_TWO_GAP = 0;
  localparam int CFG_RRD_EN = 1;
  localparam int CFG_WAR_EN = 2;
  localparam int CFG_RAW_EN = 3;
  localparam logic [CFG_W-1:0] CFG_RESET = 4'b1110;

  typedef enum logic [2:0] {
    ST_FREE, ST_GAP1, ST_GAP2, ST_A1, ST_A2, ST_A3
  } seqState_t;

  typedef struct packed {
    logic capture;   // request taken this cycle
    logic launch;    // next state is A1
    logic ale;       // state A1
    logic active;    // A1..A3
    logic strobe;    // A2..A3
    logic sample;    // A3
  } busStrobe_t;
endpackage

// File: rtl/ebt_seq_ctrl.sv
module ebt_seq_ctrl
  import ebt_pkg::*;
#(
  parameter int AREA_W = 3,
  parameter bit RAW_GAP_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrite,
  input  logic [CFG_W-1:0]  cfgData,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [AREA_W-1:0] reqArea,
  input  logic              curWrite,
  input  logic [AREA_W-1:0] curArea,
  output logic              reqReady,
  output logic              done,
  output busStrobe_t        stb
);
  seqState_t state, nextState;
  logic [CFG_W-1:0] cfgQ;
  logic twoGapQ;
  logic take, hazard, rrdHaz, warHaz, rawHaz;

  always_ff @(posedge clk) begin
    if (!rstN) cfgQ <= CFG_RESET;
    else if (cfgWrite) cfgQ <= cfgData;
  end

  assign reqReady = (state == ST_FREE) || (state == ST_A3);
  assign take = reqValid && reqReady;

  assign rrdHaz = cfgQ[CFG_RRD_EN] && !curWrite && !reqWrite && (reqArea != curArea);
  assign warHaz = cfgQ[CFG_WAR_EN] && !curWrite && reqWrite;

  generate
    if (RAW_GAP_EN) begin : g_raw
      assign rawHaz = cfgQ[CFG_RAW_EN] && curWrite && !reqWrite;
    end else begin : g_noRaw
      assign rawHaz = 1'b0;
    end
  endgenerate

  // only a request taken in A3 is back to back with the running access
  assign hazard = (state == ST_A3) && (rrdHaz || warHaz || rawHaz);

  always_comb begin
    nextState = state;
    case (state)
      ST_FREE: nextState = take ? ST_A1 : ST_FREE;
      ST_GAP1: nextState = twoGapQ ? ST_GAP2 : ST_A1;
      ST_GAP2: nextState = ST_A1;
      ST_A1:   nextState = ST_A2;
      ST_A2:   nextState = ST_A3;
      ST_A3:   nextState = take ? (hazard ? ST_GAP1 : ST_A1) : ST_FREE;
      default: nextState = ST_FREE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_FREE;
      twoGapQ <= 1'b0;
      done    <= 1'b0;
    end else begin
      state <= nextState;
      if (take && hazard) twoGapQ <= cfgQ[CFG_TWO_GAP];
      done <= (state == ST_A3);
    end
  end

  always_comb begin
    stb.capture = take;
    stb.launch  = (nextState == ST_A1);
    stb.ale     = (state == ST_A1);
    stb.active  = (state == ST_A1) || (state == ST_A2) || (state == ST_A3);
    stb.strobe  = (state == ST_A2) || (state == ST_A3);
    stb.sample  = (state == ST_A3);
  end
endmodule

// File: rtl/ebt_bus_dp.sv
module ebt_bus_dp
  import ebt_pkg::*;
#(
  parameter int NUM_AREAS = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  localparam int AREA_W = $clog2(NUM_AREAS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  busStrobe_t           stb,
  input  logic                 reqWrite,
  input  logic [AREA_W-1:0]    reqArea,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [DATA_W-1:0]    reqWdata,
  input  logic [DATA_W-1:0]    busDin,
  output logic                 curWrite,
  output logic [AREA_W-1:0]    curArea,
  output logic [NUM_AREAS-1:0] busCs,
  output logic                 busAle,
  output logic                 busRd,
  output logic                 busWr,
  output logic [ADDR_W-1:0]    busAddr,
  output logic [DATA_W-1:0]    busDout,
  output logic                 busDoutEn,
  output logic [DATA_W-1:0]    rdData
);
  logic pendWrite;
  logic [AREA_W-1:0] pendArea;
  logic [ADDR_W-1:0] pendAddr;
  logic [DATA_W-1:0] pendWdata, curWdata;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendWrite <= 1'b0;
      pendArea  <= '0;
      pendAddr  <= '0;
      pendWdata <= '0;
      curWrite  <= 1'b0;
      curArea   <= '0;
      busAddr   <= '0;
      curWdata  <= '0;
      rdData    <= '0;
    end else begin
      if (stb.capture) begin
        pendWrite <= reqWrite;
        pendArea  <= reqArea;
        pendAddr  <= reqAddr;
        pendWdata <= reqWdata;
      end
      // a request may go straight to A1 or wait behind turnaround states
      if (stb.launch) begin
        curWrite <= stb.capture ? reqWrite : pendWrite;
        curArea  <= stb.capture ? reqArea  : pendArea;
        busAddr  <= stb.capture ? reqAddr  : pendAddr;
        curWdata <= stb.capture ? reqWdata : pendWdata;
      end
      if (stb.sample && !curWrite) rdData <= busDin;
    end
  end

  generate
    for (genvar i = 0; i < NUM_AREAS; i++) begin : g_cs
      assign busCs[i] = stb.active && (curArea == AREA_W'(i));
    end
  endgenerate

  assign busAle    = stb.ale;
  assign busRd     = stb.strobe && !curWrite;
  assign busWr     = stb.strobe && curWrite;
  assign busDoutEn = stb.active && curWrite;
  assign busDout   = curWdata;
endmodule

// File: rtl/ext_bus_turnaround.sv
module ext_bus_turnaround
  import ebt_pkg::*;
#(
  parameter int NUM_AREAS = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter bit RAW_GAP_EN = 1'b1,
  localparam int AREA_W = $clog2(NUM_AREAS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWrite,
  input  logic [CFG_W-1:0]     cfgData,
  input  logic                 reqValid,
  output logic                 reqReady,
  input  logic                 reqWrite,
  input  logic [AREA_W-1:0]    reqArea,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [DATA_W-1:0]    reqWdata,
  output logic [NUM_AREAS-1:0] busCs,
  output logic                 busAle,
  output logic                 busRd,
  output logic                 busWr,
  output logic [ADDR_W-1:0]    busAddr,
  output logic [DATA_W-1:0]    busDout,
  output logic                 busDoutEn,
  input  logic [DATA_W-1:0]    busDin,
  output logic [DATA_W-1:0]    rdData,
  output logic                 done
);
  busStrobe_t stb;
  logic curWrite;
  logic [AREA_W-1:0] curArea;

  ebt_seq_ctrl #(.AREA_W(AREA_W), .RAW_GAP_EN(RAW_GAP_EN)) ctrl_i (
    .clk(clk), .rstN(rstN), .cfgWrite(cfgWrite), .cfgData(cfgData),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqArea(reqArea),
    .curWrite(curWrite), .curArea(curArea), .reqReady(reqReady),
    .done(done), .stb(stb)
  );

  ebt_bus_dp #(.NUM_AREAS(NUM_AREAS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .reqWrite(reqWrite), .reqArea(reqArea),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .busDin(busDin),
    .curWrite(curWrite), .curArea(curArea), .busCs(busCs), .busAle(busAle),
    .busRd(busRd), .busWr(busWr), .busAddr(busAddr), .busDout(busDout),
    .busDoutEn(busDoutEn), .rdData(rdData)
  );
endmodule

// File: rtl/ebt_checker.sv
module ebt_checker #(
  parameter int NUM_AREAS = 8,
  parameter int ADDR_W = 16
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_AREAS-1:0] busCs,
  input logic                 busAle,
  input logic                 busRd,
  input logic                 busWr,
  input logic [ADDR_W-1:0]    busAddr,
  input logic                 busDoutEn,
  input logic                 done
);
  p_cs_onehot_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(busCs));

  p_ale_single_r1: assert property (@(posedge clk) disable iff (!rstN)
    busAle |=> !busAle);

  p_done_after_access_r1: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(|busCs));

  p_strobe_after_ale_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(busRd) || $rose(busWr)) |-> $past(busAle));

  p_rd_wr_exclusive_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(busRd && busWr));

  p_quiet_gap_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(|busCs) |-> (!busRd && !busWr && !busDoutEn));

  p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !busAle |-> $stable(busAddr));
endmodule

bind ext_bus_turnaround ebt_checker #(.NUM_AREAS(NUM_AREAS), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .busCs(busCs), .busAle(busAle), .busRd(busRd),
  .busWr(busWr), .busAddr(busAddr), .busDoutEn(busDoutEn), .done(done)
);

// File: tb/ext_bus_turnaround_tb.sv
module ext_bus_turnaround_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NA = 8;
  localparam int AW = 16;
  localparam int DW = 16;

  typedef struct packed {
    logic            w;
    logic [2:0]      area;
    logic [AW-1:0]   addr;
    logic [DW-1:0]   data;
    logic signed [7:0] gap;
  } item_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrite = 1'b0;
  logic [3:0] cfgData = '0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [2:0] reqArea = '0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic reqReady, busAle, busRd, busWr, busDoutEn, done;
  logic [NA-1:0] busCs;
  logic [AW-1:0] busAddr;
  logic [DW-1:0] busDout, busDin, rdData;

  // second build without the read-after-write gap
  logic nrValid = 1'b0, nrWrite = 1'b0;
  logic [2:0] nrArea = '0;
  logic nrReady, nrAle, nrRd, nrWr, nrDoutEn, nrDone;
  logic [NA-1:0] nrCs;
  logic [AW-1:0] nrAddr;
  logic [DW-1:0] nrDout, nrRdData;

  int vectors = 0;
  int miscompares = 0;
  item_t expQ[$];
  string tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign busDin = busAddr ^ 16'h5A3C;

  ext_bus_turnaround dut_i (
    .clk(clk), .rstN(rstN), .cfgWrite(cfgWrite), .cfgData(cfgData),
    .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqArea(reqArea), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .busCs(busCs), .busAle(busAle), .busRd(busRd), .busWr(busWr),
    .busAddr(busAddr), .busDout(busDout), .busDoutEn(busDoutEn),
    .busDin(busDin), .rdData(rdData), .done(done)
  );

  ext_bus_turnaround #(.RAW_GAP_EN(1'b0)) dut_noraw_i (
    .clk(clk), .rstN(rstN), .cfgWrite(1'b0), .cfgData(4'b0000),
    .reqValid(nrValid), .reqReady(nrReady), .reqWrite(nrWrite),
    .reqArea(nrArea), .reqAddr(16'h0040), .reqWdata(16'h00AA),
    .busCs(nrCs), .busAle(nrAle), .busRd(nrRd), .busWr(nrWr),
    .busAddr(nrAddr), .busDout(nrDout), .busDoutEn(nrDoutEn),
    .busDin(16'h0000), .rdData(nrRdData), .done(nrDone)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send(input bit w, input logic [2:0] area, input logic [AW-1:0] addr,
                      input logic [DW-1:0] data, input int gap, input string tag);
    item_t it;
    it.w = w; it.area = area; it.addr = addr; it.data = data; it.gap = 8'(gap);
    expQ.push_back(it);
    tagQ.push_back(tag);
    reqValid = 1'b1; reqWrite = w; reqArea = area; reqAddr = addr; reqWdata = data;
    do @(negedge clk); while (!reqReady);
    @(posedge clk);
    #1;
  endtask

  task automatic pause();
    reqValid = 1'b0;
    repeat (8) @(posedge clk);
    #1;
  endtask

  task automatic setCfg(input logic [3:0] v);
    cfgWrite = 1'b1; cfgData = v;
    @(posedge clk);
    #1 cfgWrite = 1'b0;
  endtask

  // scoreboard monitor
  item_t cur;
  string curTag;
  int gapCnt = 0;
  bit inA2 = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      if (done && !cur.w)
        chk(rdData == (cur.addr ^ 16'h5A3C), "R2 read data", rdData, cur.addr ^ 16'h5A3C);
      if (busAle) begin
        if (expQ.size() == 0) chk(1'b0, "R1 unexpected access", busAddr, 0);
        else begin
          cur = expQ.pop_front();
          curTag = tagQ.pop_front();
          chk(busCs == NA'(1) << cur.area, "R1 chip select", busCs, NA'(1) << cur.area);
          chk(busAddr == cur.addr, "R1 address", busAddr, cur.addr);
          if (cur.gap >= 0)
            chk(gapCnt == int'(cur.gap), {curTag, " gap length"}, gapCnt, cur.gap);
        end
        gapCnt = 0;
        inA2 = 1'b1;
      end else begin
        if (inA2) begin
          inA2 = 1'b0;
          chk(busWr == cur.w && busRd == !cur.w, "R2 strobe in A2", {busWr, busRd}, {cur.w, !cur.w});
          if (cur.w)
            chk(busDoutEn && busDout == cur.data, "R2 write data", busDout, cur.data);
        end
        if (|busCs) gapCnt = 0;
        else gapCnt++;
      end
    end
  end

  // ale-to-ale spacing on the variant build
  int nrCnt = 0;
  bit nrSeen = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      if (nrAle) begin
        if (nrSeen) chk(nrCnt == 3, "R6 no gap without read-after-write build", nrCnt, 3);
        nrSeen = 1'b1;
        nrCnt = 1;
      end else nrCnt++;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    chk(1'b0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 R11 reset state
    chk(reqReady == 1'b1, "R11 ready after reset", reqReady, 1);
    chk(busCs == '0 && !busRd && !busWr && !done, "R10 quiet after reset", busCs, 0);
    @(posedge clk); #1;

    // R11 ready pattern across one access
    send(1'b0, 3'd0, 16'h0010, 16'h0, -1, "R1");
    reqValid = 1'b0;
    @(negedge clk); chk(!reqReady, "R11 ready in A1", reqReady, 0);
    @(negedge clk); chk(!reqReady, "R11 ready in A2", reqReady, 0);
    @(negedge clk); chk(reqReady, "R11 ready in A3", reqReady, 1);
    pause();

    // default configuration: one-state gaps, all hazards enabled
    send(1'b0, 3'd0, 16'h0100, 16'h0, -1, "R1");
    send(1'b0, 3'd0, 16'h0104, 16'h0, 0, "R4");
    send(1'b0, 3'd3, 16'h0300, 16'h0, 1, "R3");
    send(1'b1, 3'd3, 16'h0304, 16'h1234, 1, "R5");
    send(1'b1, 3'd5, 16'h0500, 16'hBEEF, 0, "R9");
    send(1'b0, 3'd5, 16'h0504, 16'h0, 1, "R6");
    send(1'b0, 3'd5, 16'h0508, 16'h0, 0, "R4");
    pause();

    // two-state gaps
    setCfg(4'b1111);
    send(1'b0, 3'd1, 16'h1100, 16'h0, -1, "R7");
    send(1'b1, 3'd1, 16'h1104, 16'h5555, 2, "R7");
    send(1'b0, 3'd1, 16'h1108, 16'h0, 2, "R7");
    send(1'b0, 3'd2, 16'h1200, 16'h0, 2, "R7");
    pause();

    // all hazards disabled
    setCfg(4'b0001);
    send(1'b0, 3'd0, 16'h2000, 16'h0, -1, "R12");
    send(1'b0, 3'd4, 16'h2400, 16'h0, 0, "R12");
    send(1'b1, 3'd4, 16'h2404, 16'hA5A5, 0, "R12");
    send(1'b0, 3'd4, 16'h2408, 16'h0, 0, "R12");
    pause();

    // only area-change reads disabled
    setCfg(4'b1100);
    send(1'b0, 3'd0, 16'h3000, 16'h0, -1, "R12");
    send(1'b0, 3'd6, 16'h3600, 16'h0, 0, "R12");
    send(1'b1, 3'd6, 16'h3604, 16'h0F0F, 1, "R5");
    send(1'b0, 3'd6, 16'h3608, 16'h0, 1, "R6");
    pause();

    // one free state replaces the turnaround
    setCfg(4'b1110);
    send(1'b0, 3'd2, 16'h4200, 16'h0, -1, "R9");
    reqValid = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    send(1'b0, 3'd7, 16'h4700, 16'h0, 1, "R9");
    pause();

    // variant build: write then read back to back
    nrValid = 1'b1; nrWrite = 1'b1; nrArea = 3'd0;
    do @(negedge clk); while (!nrReady);
    @(posedge clk); #1;
    nrWrite = 1'b0;
    do @(negedge clk); while (!nrReady);
    @(posedge clk); #1;
    nrValid = 1'b0;
    repeat (8) @(posedge clk);

    chk(expQ.size() == 0, "R1 all accesses seen", expQ.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule